// File: doc/BRIEF.md
# External Interrupt Request Flags

This block holds the pending-request flags for a set of active-low external interrupt pins (two by default). Each pin passes through a two-flop synchronizer. A per-channel trigger mode then decides how the pin sets its flag. In edge mode, a high-to-low transition of the synchronized pin sets the flag, and the flag stays set until the interrupt controller acknowledges the vector or software clears it. In level mode, the flag reflects the synchronized pin level in every cycle, so a low pin means a pending request.

The trigger modes sit in a small register that software loads through a write strobe. Software can also write the flags directly. The interrupt controller returns one acknowledge strobe per channel when it vectors to that channel's service routine. Enables, priority and vector generation are handled elsewhere.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, every flag reads 0 and every trigger mode is level (mode bit 0).
- R2: With the trigger-mode bit at 1 (edge mode), a high-to-low transition of the synchronized pin sets the flag.
- R3: In edge mode, an acknowledge pulse clears the flag on the next rising edge, unless a falling edge or a flag write arrives in the same cycle.
- R4: With the trigger-mode bit at 0 (level mode), the flag is 1 while the synchronized pin is low and 0 while it is high, outside cycles with a flag write.
- R5: In level mode, the acknowledge input has no effect on the flag.
- R6: A pin change reaches the flag on the third rising edge after the pin changes, through two synchronizer flops and then the flag register.
- R7: In edge mode, a falling edge that coincides with an acknowledge leaves the flag set.
- R8: A flag write (write-enable bit i high) loads the write-data bit into flag i. A hardware set in the same cycle wins over a written 0.
- R9: In edge mode, a pin held low sets the flag only once. After an acknowledge, the flag stays clear until the next falling edge.
- R10: Channels are independent. Bit i of every vector input affects only flag i.
- R11: A pulse on the mode write strobe loads the mode register from the mode data bus. The new modes take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | NUM_IRQ | Raw active-low interrupt pins, asynchronous |
| mode_wr | input | 1 | Strobe that loads the trigger-mode register |
| mode_wdata | input | NUM_IRQ | New trigger modes, 1 = edge, 0 = level |
| irq_ack | input | NUM_IRQ | Per-channel vector acknowledge strobes |
| flag_wr_en | input | NUM_IRQ | Per-channel software flag write enable |
| flag_wr_data | input | NUM_IRQ | Value written to the flag |
| irq_flag | output | NUM_IRQ | Pending request flags |

## Verification
The hardest situations to create are the collisions: a synchronized falling edge that lands in the same cycle as an acknowledge or a software clear. Reaching them from the ports means the stimulus has to allow for the two-flop delay. The directed phase therefore drops a pin and issues the acknowledge or the clear exactly two cycles later. The random phase then mixes pin toggles, strobes and mode changes across both channels, so that the collisions also occur in unplanned combinations.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // events seen on one synchronized pin
    typedef struct packed {
        logic lvl_low;
        logic fall;
    } pin_evt_t;

    // control strobes for one flag
    typedef struct packed {
        logic ack;
        logic wr_en;
        logic wr_data;
    } flag_ctl_t;

    // next flag value; hardware set outranks write, write outranks ack
    function automatic logic next_flag(trig_mode_e mode, pin_evt_t evt,
                                       flag_ctl_t ctl, logic cur);
        logic nxt;
        if (mode == TRIG_EDGE) begin
            if (evt.fall)        nxt = 1'b1;
            else if (ctl.wr_en)  nxt = ctl.wr_data;
            else if (ctl.ack)    nxt = 1'b0;
            else                 nxt = cur;
        end else begin
            nxt = evt.lvl_low | (ctl.wr_en & ctl.wr_data);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_n,
    output pin_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= pin_n;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b1;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    always_comb begin
        evt.lvl_low = ~chain_q[LAST];
        evt.fall    = prev_q & ~chain_q[LAST];
    end
endmodule

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [NUM_IRQ-1:0] wdata,
    output logic [NUM_IRQ-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst)     mode_q <= '0;
        else if (wr) mode_q <= wdata;
    end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  pin_evt_t   evt,
    input  flag_ctl_t  ctl,
    output logic       flag_q
);
    logic flag_d;

    always_comb flag_d = next_flag(mode, evt, ctl, flag_q);

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import ext_irq_pkg::*;
#(
    parameter int NUM_IRQ     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_pin_n,
    input  logic               mode_wr,
    input  logic [NUM_IRQ-1:0] mode_wdata,
    input  logic [NUM_IRQ-1:0] irq_ack,
    input  logic [NUM_IRQ-1:0] flag_wr_en,
    input  logic [NUM_IRQ-1:0] flag_wr_data,
    output logic [NUM_IRQ-1:0] irq_flag
);
    logic [NUM_IRQ-1:0] trig_q;
    logic [NUM_IRQ-1:0] lvl_low_v;
    logic [NUM_IRQ-1:0] fall_v;

    irq_trig_cfg #(.NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode_q(trig_q)
    );

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ch
            pin_evt_t   evt;
            flag_ctl_t  ctl;
            trig_mode_e mode;

            irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .pin_n(irq_pin_n[i]),
                .evt  (evt)
            );

            always_comb begin
                mode        = trig_mode_e'(trig_q[i]);
                ctl.ack     = irq_ack[i];
                ctl.wr_en   = flag_wr_en[i];
                ctl.wr_data = flag_wr_data[i];
                lvl_low_v[i] = evt.lvl_low;
                fall_v[i]    = evt.fall;
            end

            irq_flag_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .mode  (mode),
                .evt   (evt),
                .ctl   (ctl),
                .flag_q(irq_flag[i])
            );
        end
    endgenerate
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
    parameter int NUM_IRQ = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] trig_q,
    input logic [NUM_IRQ-1:0] lvl_low,
    input logic [NUM_IRQ-1:0] fall,
    input logic [NUM_IRQ-1:0] ack,
    input logic [NUM_IRQ-1:0] wr_en,
    input logic [NUM_IRQ-1:0] wr_data,
    input logic [NUM_IRQ-1:0] flag
);
    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_a
            p_edge_set_r2: assert property (@(posedge clk) disable iff (rst)
                (trig_q[i] && fall[i]) |=> flag[i]);

            p_ack_clear_r3: assert property (@(posedge clk) disable iff (rst)
                (trig_q[i] && ack[i] && !fall[i] && !wr_en[i]) |=> !flag[i]);

            p_level_low_r4: assert property (@(posedge clk) disable iff (rst)
                (!trig_q[i] && lvl_low[i]) |=> flag[i]);

            p_level_high_r4: assert property (@(posedge clk) disable iff (rst)
                (!trig_q[i] && !lvl_low[i] && !wr_en[i]) |=> !flag[i]);

            p_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (trig_q[i] && !fall[i] && !ack[i] && !wr_en[i])
                |=> (flag[i] == $past(flag[i])));

            p_sw_write_r8: assert property (@(posedge clk) disable iff (rst)
                (trig_q[i] && wr_en[i] && !fall[i]) |=> (flag[i] == $past(wr_data[i])));
        end
    endgenerate
endmodule

bind ext_irq_flags ext_irq_flags_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .trig_q (trig_q),
    .lvl_low(lvl_low_v),
    .fall   (fall_v),
    .ack    (irq_ack),
    .wr_en  (flag_wr_en),
    .wr_data(flag_wr_data),
    .flag   (irq_flag)
);

// File: tb/ext_irq_flags_tb.sv
module ext_irq_flags_tb;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pin_n;
    logic         mode_wr;
    logic [N-1:0] mode_wdata;
    logic [N-1:0] ack;
    logic [N-1:0] wen;
    logic [N-1:0] wdat;
    logic [N-1:0] flag;

    int total = 0;
    int bad   = 0;
    string tag = "R1";

    // independent model state
    logic [N-1:0] m_s1, m_s2, m_prev, m_mode, m_flag;

    always #5 clk = ~clk;

    ext_irq_flags #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst(rst), .irq_pin_n(pin_n), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .irq_ack(ack), .flag_wr_en(wen),
        .flag_wr_data(wdat), .irq_flag(flag)
    );

    function automatic logic exp_flag(logic edge_m, logic s, logic prv,
                                      logic a, logic we, logic wd, logic cur);
        logic f;
        f = prv & ~s;
        if (edge_m) begin
            if (f)       return 1'b1;
            else if (we) return wd;
            else if (a)  return 1'b0;
            return cur;
        end
        return ~s | (we & wd);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1; m_mode = '0; m_flag = '0;
        end else begin
            for (int i = 0; i < N; i++)
                m_flag[i] = exp_flag(m_mode[i], m_s2[i], m_prev[i], ack[i],
                                     wen[i], wdat[i], m_flag[i]);
            if (mode_wr) m_mode = mode_wdata;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_n;
        end
    end

    task automatic check_flags(logic [N-1:0] expv);
        total++;
        if (flag !== expv) begin
            bad++;
            $display("FAIL %s: irq_flag=%b expected=%b at %0t", tag, flag, expv, $time);
        end
    endtask

    // sample at negedge, then drive one cycle of inputs
    task automatic step(logic [N-1:0] p, logic [N-1:0] a = '0,
                        logic [N-1:0] we = '0, logic [N-1:0] wd = '0,
                        logic mw = 1'b0, logic [N-1:0] md = '0);
        @(negedge clk);
        check_flags(m_flag);
        pin_n = p; ack = a; wen = we; wdat = wd; mode_wr = mw; mode_wdata = md;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: expired, expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; pin_n = '1; mode_wr = 0; mode_wdata = '0;
        ack = '0; wen = '0; wdat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        check_flags(2'b00);
        // default level mode: low pin raises flag
        step(2'b10);
        repeat (4) step(2'b10);
        check_flags(2'b01);
        step(2'b11);
        repeat (4) step(2'b11);

        // R11: switch ch0 to edge mode
        tag = "R11";
        step(2'b11, '0, '0, '0, 1'b1, 2'b01);
        repeat (3) step(2'b11);

        // R6 / R2: latency of an edge
        tag = "R6";
        step(2'b10);
        check_flags(2'b00);
        step(2'b10);
        check_flags(2'b00);
        step(2'b10);
        tag = "R2";
        step(2'b10);
        check_flags(2'b01);

        // R9: held low, ack, stays clear
        tag = "R3";
        step(2'b10, 2'b01);
        step(2'b10);
        tag = "R9";
        check_flags(2'b00);
        repeat (4) step(2'b10);

        // R7: set flag, then fall coincides with ack
        tag = "R7";
        step(2'b11);
        repeat (3) step(2'b11, '0, 2'b01, 2'b01);
        repeat (3) step(2'b11);
        step(2'b10);
        step(2'b10);
        step(2'b10, 2'b01);
        step(2'b10);
        check_flags(2'b01);

        // R8: write clear, write set, clear against fall
        tag = "R8";
        step(2'b11, '0, 2'b01, 2'b00);
        step(2'b11);
        check_flags(2'b00);
        step(2'b11, '0, 2'b01, 2'b01);
        step(2'b11);
        check_flags(2'b01);
        step(2'b11, '0, 2'b01, 2'b00);
        step(2'b11);
        step(2'b10);
        step(2'b10);
        step(2'b10, '0, 2'b01, 2'b00);
        step(2'b10);
        check_flags(2'b01);

        // R4 / R5: level mode ignores ack, follows pin
        tag = "R5";
        step(2'b10, '0, '0, '0, 1'b1, 2'b00);
        repeat (4) step(2'b10, 2'b11);
        check_flags(2'b01);
        tag = "R4";
        step(2'b11);
        repeat (3) step(2'b11);
        check_flags(2'b00);

        // R10: random mix across channels
        tag = "R10";
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] p, a, we, wd, md;
            logic mw;
            p  = ($urandom % 4 == 0) ? N'($urandom) : pin_n;
            a  = N'($urandom) & N'($urandom);
            we = N'($urandom) & N'($urandom) & N'($urandom);
            wd = N'($urandom);
            mw = ($urandom % 40 == 0);
            md = N'($urandom);
            step(p, a, we, wd, mw, md);
        end
        step('1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule